// File: doc/BRIEF.md
# Timer Prescaler Front End with Debug Freeze

This block sits at the input side of a general-purpose timer. A 9-bit prescaler runs on every clock and offers a set of divided taps from which a later counter stage picks its count rate. A bank of two-stage synchronizers brings the asynchronous timer pins into the clock domain. A rising edge on any synchronized pin raises an event. An edge counter accumulates rising edges on one chosen pin. Prescaler wrap, counter overflow and pin edges set sticky status flags. A mask word selects which of these flags drive the interrupt line.

For debugging without a debug port, software can set a stop bit. While it is set, the prescaler and the edge counter hold, the synchronizers ignore the pins, and the pin view returns the levels latched when the stop took effect. While stopped, software can write a self-clearing step bit. Each step advances the prescaler by one count and clocks the synchronizers once. Software can repeat the step as often as it likes.

Top module: `tmr_front`

## Requirements
- R1: After reset the prescaler, edge counter, flags, mask, stop bit, step bit, pin view and interrupt are all zero.
- R2: While running, the prescaler adds one on every clock edge and wraps from 511 to 0. Tap k (k = 0..6) equals prescaler bit k+1, which is a divide-by-2^(k+2) square wave.
- R3: While running, a pin level appears on the pin view two edges after it is applied. A rising edge on pin i sets flag bit i one edge later, i.e. at the third edge.
- R4: The edge counter adds one for each rising edge on pin 0, at the same edge that sets flag bit 0. It wraps from 255 to 0, and the wrap sets flag bit 8.
- R5: While the stop bit is set and no step is pending, the prescaler and the edge counter hold their values.
- R6: While stopped with no step pending, pin changes do not reach the synchronizers and set no flags.
- R7: While stopped, the pin view returns the synchronized pin levels captured at the edge where the stop bit was written from 0 to 1.
- R8: A control write with stop=1 and step=1 while already stopped makes the step bit read 1 for one cycle. The next edge then advances the prescaler by exactly one, clocks the synchronizers once and clears the step bit. This can be repeated.
- R9: A step request in a write made while the stop bit is clear, or in a write that clears the stop bit, is ignored: the step bit stays 0 and no extra count occurs.
- R10: Flags clear when 1 is written to their bit, per byte lane (lane 0 = bits 7:0, lane 1 = bits 15:8). A write never sets a flag. The prescaler wrap sets flag bit 9.
- R11: If a hardware event and a clear write hit the same flag in the same cycle, the flag ends up set.
- R12: The interrupt is high while any flag whose mask bit is 1 is set. Mask writes go per byte lane. The interrupt stays high until the flag is cleared or masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_stop_i | input | 1 | Stop bit value written |
| ctl_step_i | input | 1 | Step bit value written |
| pins_i | input | 4 | Asynchronous timer pins |
| flag_we_i | input | 2 | Flag clear byte-lane strobes |
| flag_wdata_i | input | 16 | Write-1-to-clear flag data |
| msk_we_i | input | 2 | Mask byte-lane write strobes |
| msk_wdata_i | input | 16 | Mask write data |
| presc_o | output | 9 | Prescaler count |
| tap_o | output | 7 | Prescaler taps, divide by 4 to 256 |
| acc_o | output | 8 | Edge counter value |
| pin_view_o | output | 4 | Pin view: live synchronized or frozen snapshot |
| flags_o | output | 16 | Status flags |
| irq_o | output | 1 | Interrupt request |
| stop_o | output | 1 | Stop bit readback |
| step_o | output | 1 | Step bit readback |

## Verification
The freeze logic is tried with several pin patterns. Pins that rise while running must flag and count. Pins that change while stopped must leave no trace. Pins that change while stopped and are then pulled in by two steps must be visible right after the release, which tells a stepped synchronizer apart from a held one. Step requests are sent while stopped, while running, and together with the write that sets the stop bit, which separates a step that is honoured from one that is dropped. The flag logic is driven with a clear on the wrong byte lane, an all-ones write to empty flags, and a clear that lands on the exact wrap cycle. Together these expose lane decoding, write-set leaks and the set-versus-clear priority.

// File: rtl/tmr_front_pkg.sv
package tmr_front_pkg;
    localparam int FLAG_W        = 16;
    localparam int FLAG_LANES    = FLAG_W / 8;
    localparam int FLAG_ACC_OVF  = 8;
    localparam int FLAG_PRE_WRAP = 9;
endpackage

// File: rtl/tmr_sync_bank.sv
module tmr_sync_bank #(
    parameter int NPIN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv_i,
    input  logic [NPIN-1:0] pins_i,
    output logic [NPIN-1:0] sync_o,
    output logic [NPIN-1:0] rise_o
);
    typedef struct packed {
        logic [NPIN-1:0] s1;
        logic [NPIN-1:0] s2;
        logic [NPIN-1:0] s3;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d = q;
        if (adv_i) begin
            d.s1 = pins_i;
            d.s2 = q.s1;
            d.s3 = q.s2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sync_o = q.s2;

    for (genvar i = 0; i < NPIN; i++) begin : g_edge
        assign rise_o[i] = adv_i & q.s2[i] & ~q.s3[i];
    end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv_i,
    output logic [W-1:0] count_o,
    output logic [W-3:0] taps_o,
    output logic         wrap_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } pre_t;

    pre_t q, d;

    always_comb begin
        d = q;
        if (adv_i) d.cnt = q.cnt + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign count_o = q.cnt;
    assign taps_o  = q.cnt[W-2:1];
    assign wrap_o  = adv_i & (&q.cnt);
endmodule

// File: rtl/tmr_flag_bank.sv
module tmr_flag_bank
    import tmr_front_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [FLAG_W-1:0]     evt_i,
    input  logic [FLAG_LANES-1:0] clr_we_i,
    input  logic [FLAG_W-1:0]     clr_data_i,
    input  logic [FLAG_LANES-1:0] msk_we_i,
    input  logic [FLAG_W-1:0]     msk_data_i,
    output logic [FLAG_W-1:0]     flags_o,
    output logic                  irq_o
);
    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic [FLAG_W-1:0] mask;
    } fb_t;

    fb_t q, d;

    always_comb begin
        d = q;
        for (int l = 0; l < FLAG_LANES; l++) begin
            if (clr_we_i[l]) d.flags[l*8 +: 8] = q.flags[l*8 +: 8] & ~clr_data_i[l*8 +: 8];
            if (msk_we_i[l]) d.mask[l*8 +: 8]  = msk_data_i[l*8 +: 8];
        end
        d.flags = d.flags | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign flags_o = q.flags;
    assign irq_o   = |(q.flags & q.mask);
endmodule

// File: rtl/tmr_front.sv
module tmr_front
    import tmr_front_pkg::*;
#(
    parameter int NPIN    = 4,
    parameter int PRE_W   = 9,
    parameter int ACC_W   = 8,
    parameter int ACC_PIN = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctl_we_i,
    input  logic                  ctl_stop_i,
    input  logic                  ctl_step_i,
    input  logic [NPIN-1:0]       pins_i,
    input  logic [FLAG_LANES-1:0] flag_we_i,
    input  logic [FLAG_W-1:0]     flag_wdata_i,
    input  logic [FLAG_LANES-1:0] msk_we_i,
    input  logic [FLAG_W-1:0]     msk_wdata_i,
    output logic [PRE_W-1:0]      presc_o,
    output logic [PRE_W-3:0]      tap_o,
    output logic [ACC_W-1:0]      acc_o,
    output logic [NPIN-1:0]       pin_view_o,
    output logic [FLAG_W-1:0]     flags_o,
    output logic                  irq_o,
    output logic                  stop_o,
    output logic                  step_o
);
    typedef struct packed {
        logic             stop;
        logic             step;
        logic [NPIN-1:0]  snap;
        logic [ACC_W-1:0] acc;
    } ctl_t;

    ctl_t q, d;

    logic              adv_w;
    logic [NPIN-1:0]   sync_w;
    logic [NPIN-1:0]   rise_w;
    logic              wrap_w;
    logic              acc_inc_w;
    logic              acc_ovf_w;
    logic [FLAG_W-1:0] evt_w;

    assign adv_w     = ~q.stop | q.step;
    assign acc_inc_w = ~q.stop & rise_w[ACC_PIN];
    assign acc_ovf_w = acc_inc_w & (&q.acc);

    tmr_prescaler #(.W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (adv_w),
        .count_o (presc_o),
        .taps_o  (tap_o),
        .wrap_o  (wrap_w)
    );

    tmr_sync_bank #(.NPIN(NPIN)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (adv_w),
        .pins_i (pins_i),
        .sync_o (sync_w),
        .rise_o (rise_w)
    );

    always_comb begin
        evt_w                = '0;
        evt_w[NPIN-1:0]      = rise_w;
        evt_w[FLAG_ACC_OVF]  = acc_ovf_w;
        evt_w[FLAG_PRE_WRAP] = wrap_w;
    end

    tmr_flag_bank u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_w),
        .clr_we_i   (flag_we_i),
        .clr_data_i (flag_wdata_i),
        .msk_we_i   (msk_we_i),
        .msk_data_i (msk_wdata_i),
        .flags_o    (flags_o),
        .irq_o      (irq_o)
    );

    always_comb begin
        d      = q;
        d.step = 1'b0;
        if (ctl_we_i) begin
            d.stop = ctl_stop_i;
            d.step = ctl_step_i & ctl_stop_i & q.stop;
            if (ctl_stop_i && !q.stop) d.snap = sync_w;
        end
        if (acc_inc_w) d.acc = q.acc + ACC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign acc_o      = q.acc;
    assign pin_view_o = q.stop ? q.snap : sync_w;
    assign stop_o     = q.stop;
    assign step_o     = q.step;
endmodule

// File: rtl/tmr_front_chk.sv
module tmr_front_chk #(
    parameter int NPIN  = 4,
    parameter int PRE_W = 9,
    parameter int ACC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stop,
    input logic             step,
    input logic [PRE_W-1:0] presc,
    input logic [ACC_W-1:0] acc,
    input logic [NPIN-1:0]  pin_view,
    input logic [15:0]      flags,
    input logic [15:0]      evt,
    input logic             irq,
    input logic [1:0]       flag_we,
    input logic [1:0]       msk_we
);
    assert_hold_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !step) |=> ($stable(presc) && $stable(acc)));

    assert_step_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && step) |=> (presc == PRE_W'($past(presc) + 1'b1)));

    assert_step_needs_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !stop |-> !step);

    assert_view_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!stop || $stable(pin_view)));

    assert_hw_only_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & ~$past(flags) & ~$past(evt)) == 16'h0000));

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != 16'h0000) |=> ((flags & $past(evt)) == $past(evt)));

    assert_irq_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && flag_we == 2'b00 && msk_we == 2'b00) |=> irq);
endmodule

bind tmr_front tmr_front_chk #(.NPIN(NPIN), .PRE_W(PRE_W), .ACC_W(ACC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop     (stop_o),
    .step     (step_o),
    .presc    (presc_o),
    .acc      (acc_o),
    .pin_view (pin_view_o),
    .flags    (flags_o),
    .evt      (evt_w),
    .irq      (irq_o),
    .flag_we  (flag_we_i),
    .msk_we   (msk_we_i)
);

// File: tb/tmr_front_bench.sv
module tmr_front_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctl_we, ctl_stop, ctl_step;
    logic [3:0]  pins;
    logic [1:0]  flag_we, msk_we;
    logic [15:0] flag_wdata, msk_wdata;
    logic [8:0]  presc;
    logic [6:0]  tap;
    logic [7:0]  acc;
    logic [3:0]  view;
    logic [15:0] flags;
    logic        irq, stop, step;

    always #5 clk = ~clk;

    tmr_front u_tmr_front (
        .clk(clk), .rst_n(rst_n), .ctl_we_i(ctl_we), .ctl_stop_i(ctl_stop),
        .ctl_step_i(ctl_step), .pins_i(pins), .flag_we_i(flag_we),
        .flag_wdata_i(flag_wdata), .msk_we_i(msk_we), .msk_wdata_i(msk_wdata),
        .presc_o(presc), .tap_o(tap), .acc_o(acc), .pin_view_o(view),
        .flags_o(flags), .irq_o(irq), .stop_o(stop), .step_o(step)
    );

    localparam int S_PRESC = 0, S_TAP = 1, S_ACC = 2, S_VIEW = 3, S_FLAGS = 4,
                   S_FLAGSNW = 5, S_IRQ = 6, S_STOP = 7, S_STEP = 8, S_FLAG8 = 9;

    typedef struct {
        int    sel;
        int    exp;
        string req;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    int    m_presc = 0;
    bit    m_stop  = 1'b0;
    bit    m_step  = 1'b0;

    function automatic int actual(int sel);
        case (sel)
            S_PRESC:   return int'(presc);
            S_TAP:     return int'(tap);
            S_ACC:     return int'(acc);
            S_VIEW:    return int'(view);
            S_FLAGS:   return int'(flags);
            S_FLAGSNW: return int'(flags & 16'hFDFF);
            S_IRQ:     return int'(irq);
            S_STOP:    return int'(stop);
            S_STEP:    return int'(step);
            default:   return int'(flags[8]);
        endcase
    endfunction

    task automatic chk(input int sel, input int exp, input string req);
        item_t it;
        it.sel = sel; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    // monitor: pops expectations half a cycle after they were queued
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                int    a;
                it = q.pop_front();
                a  = actual(it.sel);
                checks++;
                if (a !== it.exp) begin
                    errors++;
                    $display("FAIL %s sel=%0d actual=%0h expected=%0h", it.req, it.sel, a, it.exp);
                end
            end
        end
    end

    // one clock edge, with the prescaler and control bits tracked from the requirements
    task automatic tick();
        bit nstep;
        if (!m_stop || m_step) m_presc = (m_presc + 1) % 512;
        nstep = ctl_we && ctl_step && ctl_stop && m_stop;
        if (ctl_we) m_stop = ctl_stop;
        m_step = nstep;
        @(posedge clk);
        #2;
    endtask

    task automatic pulse0();
        pins = 4'b0001; repeat (3) tick();
        pins = 4'b0000; repeat (3) tick();
    endtask

    initial begin
        rst_n = 1'b0; ctl_we = 0; ctl_stop = 0; ctl_step = 0; pins = 0;
        flag_we = 0; flag_wdata = 0; msk_we = 0; msk_wdata = 0;
        repeat (3) @(posedge clk);
        #2;
        chk(S_PRESC, 0, "R1"); chk(S_ACC, 0, "R1"); chk(S_FLAGS, 0, "R1");
        chk(S_IRQ, 0, "R1"); chk(S_STOP, 0, "R1"); chk(S_STEP, 0, "R1"); chk(S_VIEW, 0, "R1");
        rst_n = 1'b1;

        repeat (10) tick();
        chk(S_PRESC, m_presc, "R2"); chk(S_TAP, (m_presc >> 1) & 127, "R2");
        repeat (37) tick();
        chk(S_PRESC, m_presc, "R2"); chk(S_TAP, (m_presc >> 1) & 127, "R2");

        msk_we = 2'b10; msk_wdata = 16'h0200; tick(); msk_we = 2'b00;
        while (m_presc != 511) tick();
        flag_we = 2'b10; flag_wdata = 16'h0200; tick(); flag_we = 2'b00;
        chk(S_PRESC, 0, "R2 wrap"); chk(S_FLAGS, 16'h0200, "R11 set beats clear");
        chk(S_IRQ, 1, "R12");
        repeat (4) tick();
        chk(S_IRQ, 1, "R12 sticky");
        flag_we = 2'b01; tick(); flag_we = 2'b00;
        chk(S_FLAGS, 16'h0200, "R10 wrong lane");
        flag_we = 2'b10; tick(); flag_we = 2'b00;
        chk(S_FLAGS, 0, "R10 clear"); chk(S_IRQ, 0, "R12 cleared");
        flag_we = 2'b11; flag_wdata = 16'hFFFF; tick(); flag_we = 2'b00;
        chk(S_FLAGS, 0, "R10 no write set");

        pins = 4'b0001; tick();
        chk(S_VIEW, 0, "R3");
        tick();
        chk(S_VIEW, 1, "R3"); chk(S_FLAGSNW, 0, "R3");
        tick();
        chk(S_FLAGSNW, 16'h0001, "R3"); chk(S_ACC, 1, "R4"); chk(S_IRQ, 0, "R12 masked");
        pins = 4'b0101; repeat (3) tick();
        chk(S_FLAGSNW, 16'h0005, "R3"); chk(S_ACC, 1, "R4 other pin");
        flag_we = 2'b01; flag_wdata = 16'h00FF; tick(); flag_we = 2'b00;
        chk(S_FLAGSNW, 0, "R10");

        ctl_we = 1; ctl_stop = 1; tick(); ctl_we = 0;
        chk(S_STOP, 1, "R7");
        pins = 4'b1010; repeat (2) tick();
        pins = 4'b1011; repeat (3) tick();
        chk(S_PRESC, m_presc, "R5"); chk(S_ACC, 1, "R5");
        chk(S_VIEW, 4'b0101, "R7"); chk(S_FLAGSNW, 0, "R6");

        for (int s = 0; s < 2; s++) begin
            ctl_we = 1; ctl_stop = 1; ctl_step = 1; tick(); ctl_we = 0; ctl_step = 0;
            chk(S_STEP, 1, "R8"); chk(S_PRESC, m_presc, "R8 hold");
            tick();
            chk(S_STEP, 0, "R8"); chk(S_PRESC, m_presc, "R8 one count");
        end
        chk(S_VIEW, 4'b0101, "R7");
        ctl_we = 1; ctl_stop = 0; tick(); ctl_we = 0;
        chk(S_STOP, 0, "R8"); chk(S_VIEW, 4'b1011, "R8 sync stepped");
        tick();
        chk(S_FLAGSNW, 16'h000A, "R3"); chk(S_ACC, 1, "R4"); chk(S_PRESC, m_presc, "R2");
        flag_we = 2'b01; tick(); flag_we = 2'b00;

        ctl_we = 1; ctl_stop = 0; ctl_step = 1; tick(); ctl_we = 0; ctl_step = 0;
        chk(S_STEP, 0, "R9 running");
        tick();
        chk(S_PRESC, m_presc, "R9");
        ctl_we = 1; ctl_stop = 1; ctl_step = 1; tick(); ctl_we = 0; ctl_step = 0;
        chk(S_STEP, 0, "R9 entry");
        tick();
        chk(S_PRESC, m_presc, "R9 held");
        ctl_we = 1; ctl_stop = 0; tick(); ctl_we = 0;

        pins = 4'b0000; repeat (4) tick();
        flag_we = 2'b11; flag_wdata = 16'hFFFF; tick(); flag_we = 2'b00;
        for (int p = 0; p < 254; p++) pulse0();
        chk(S_ACC, 255, "R4"); chk(S_FLAG8, 0, "R4");
        pulse0();
        chk(S_ACC, 0, "R4 wrap"); chk(S_FLAG8, 1, "R4 overflow flag");

        @(negedge clk);
        #1;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule